// File: doc/BRIEF.md
# Error-Locating Sequencer

This block streams a 256-position message, one bit per step, into an 8-bit polynomial-division shift register and stops on its own. A step counter supplies the current position to an external message store. The store returns the bit combinationally, except that the final eight positions take their bits from an 8-bit switch input. A two-state controller starts in its running state after reset, advances the counter and the shift register together on each step, and drops into a halted state that only reset leaves.

The mode input selects the job. In parity mode (`parityMode` = 1) all 256 positions are consumed and the output shows the final shift-register contents. With the switches at zero, those contents are the check bits of the message. With the check bits on the switches, the contents are zero for an intact message. In locate mode (`parityMode` = 0), the run halts as soon as the registered shift-register contents equal the switch pattern, and the output shows the step count reached. A count of 0 means no error. A prescaler can slow stepping to one step per 65536 clocks, or it can be bypassed so that the block steps on every clock.

Top module: `errLocateSeq`

## Requirements
- R1: After reset the controller is running, `done` is 0, `msgAddr` is 0 and the shift register holds 0, so `result` is 0 in parity mode.
- R2: Each step raises `msgAddr` (the step count) by one. The count holds at 255 once reached.
- R3: A step with input bit b turns state s into ({s[6:0], b}) XOR (s[7] ? 8'h1D : 8'h00). This is division by x^8+x^4+x^3+x^2+1.
- R4: At positions 248+i (i = 0..7) the bit is `sw[7-i]` and `msgBit` is ignored. Appending the parity-mode check bits on the switches therefore gives a final state of 0.
- R5: In parity mode the step at count 255 is the last one. `done` rises after exactly 256 steps and `result` equals the shift-register state.
- R6: In locate mode, whenever the controller is running and the registered state equals `sw`, the run halts with no further step and `result` shows the count. This test also applies before the first step, so `sw` = 0 gives a result of 0 at once.
- R7: In locate mode with no match, the run halts after the step at count 255 and `result` is 255.
- R8: Once halted, `done` stays 1 and the count and state are frozen until reset, whatever `msgBit`, `sw` or the mode do.
- R9: With `slowEn` = 0 a step occurs on every clock. With `slowEn` = 1 a step occurs once per 65536 clocks, the first on the 65536th clock after reset.
- R10: In parity mode an equality between the state and `sw` does not stop the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slowEn | input | 1 | 1: step once per 65536 clocks; 0: step every clock |
| parityMode | input | 1 | 1: parity over all positions; 0: locate by match |
| sw | input | 8 | Switch pattern: tail bits and match target |
| msgBit | input | 1 | Message bit at position `msgAddr` |
| msgAddr | output | 8 | Step count and message position |
| done | output | 1 | Controller halted |
| result | output | 8 | Shift-register state (parity mode) or count (locate mode) |

## Verification
A pseudo-random message with zero switches yields the check bits, which are compared with a division computed in the bench. The same message is then rerun with those check bits on the switches and garbage in the store's tail, which tells apart correct tail substitution (zero result) from any use of `msgBit` there. A single flipped bit gives a non-zero syndrome, and locate mode with that syndrome on the switches must halt at the first matching count. All-zero messages tell apart a match-driven stop from a terminal-count stop: in locate mode a pattern that never matches ends at 255, an immediate match ends at 0, and in parity mode a match from the outset must be ignored.

// File: rtl/esPkg.sv
package esPkg;
  typedef enum logic {
    ST_ACTIVE = 1'b0,
    ST_DONE   = 1'b1
  } esState_e;

  typedef struct packed {
    logic step;
    logic halt;
  } esStrobe_t;
endpackage

// File: rtl/esPrescale.sv
module esPrescale #(
  parameter int PRE_W = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic slowEn,
  output logic tick
);
  logic [PRE_W-1:0] preCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else if (slowEn) preCnt <= preCnt + 1'b1;
  end

  assign tick = slowEn ? (&preCnt) : 1'b1;

  // R9: in slow stepping, two consecutive ticks cannot occur
  p_tick_spaced_r9: assert property (@(posedge clk) disable iff (!rstN)
    (slowEn && tick) |=> (!slowEn || !tick));
endmodule

// File: rtl/esCtrl.sv
module esCtrl
  import esPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      parityMode,
  input  logic      tc,
  input  logic      match,
  output esStrobe_t strobe
);
  esState_e state, nextState;
  logic active, hitMatch;

  assign active   = (state == ST_ACTIVE);
  assign hitMatch = !parityMode && match;

  always_comb begin
    strobe.step = active && tick && !hitMatch;
    strobe.halt = !active;
    nextState   = state;
    if (active && (hitMatch || (strobe.step && tc))) nextState = ST_DONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_ACTIVE;
    else       state <= nextState;
  end

  // R8: halted state is only left through reset
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE) |=> (state == ST_DONE));

  // R6: match in locate mode halts the run
  p_match_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (active && !parityMode && match) |=> (state == ST_DONE));

  // R5: the last step halts the run
  p_tc_stop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && tc) |=> (state == ST_DONE));

  // R10: in parity mode only the terminal count stops the run
  p_ignore_match_r10: assert property (@(posedge clk) disable iff (!rstN)
    (active && parityMode && !(tick && tc)) |=> (state == ST_ACTIVE));
endmodule

// File: rtl/esDatapath.sv
module esDatapath
  import esPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MSG_LEN = 256,
  parameter logic [DATA_W-1:0] POLY = 8'h1D,
  localparam int CNT_W = $clog2(MSG_LEN),
  localparam int RES_W = (DATA_W > CNT_W) ? DATA_W : CNT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  esStrobe_t        strobe,
  input  logic             msgBit,
  input  logic [DATA_W-1:0] sw,
  input  logic             parityMode,
  output logic [CNT_W-1:0] msgAddr,
  output logic             tc,
  output logic             match,
  output logic [RES_W-1:0] result
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MSG_LEN - 1);

  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] lfsr, nextLfsr;
  logic              inBit, fb;

  // tail positions come from the switches, last position from bit 0
  always_comb begin
    inBit = msgBit;
    for (int i = 0; i < DATA_W; i++) begin
      if (cnt == LAST - CNT_W'(i)) inBit = sw[i];
    end
  end

  assign fb = lfsr[DATA_W-1];
  assign nextLfsr[0] = inBit ^ (POLY[0] & fb);
  for (genvar k = 1; k < DATA_W; k++) begin : g_tap
    assign nextLfsr[k] = lfsr[k-1] ^ (POLY[k] & fb);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      lfsr <= '0;
    end else if (strobe.step) begin
      lfsr <= nextLfsr;
      if (!tc) cnt <= cnt + 1'b1;
    end
  end

  assign tc      = (cnt == LAST);
  assign match   = (lfsr == sw);
  assign msgAddr = cnt;
  assign result  = parityMode ? RES_W'(lfsr) : RES_W'(cnt);

  // R2: a step below the last position advances the count by one
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !tc) |=> (cnt == $past(cnt) + 1'b1));

  // R8: without a step, count and state are frozen
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.step) |=> ($stable(lfsr) && $stable(cnt)));
endmodule

// File: rtl/errLocateSeq.sv
module errLocateSeq
  import esPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MSG_LEN = 256,
  parameter int PRE_W   = 16,
  parameter logic [DATA_W-1:0] POLY = 8'h1D,
  localparam int CNT_W = $clog2(MSG_LEN),
  localparam int RES_W = (DATA_W > CNT_W) ? DATA_W : CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowEn,
  input  logic              parityMode,
  input  logic [DATA_W-1:0] sw,
  input  logic              msgBit,
  output logic [CNT_W-1:0]  msgAddr,
  output logic              done,
  output logic [RES_W-1:0]  result
);
  esStrobe_t strobe;
  logic tick, tc, match;

  esPrescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rstN(rstN), .slowEn(slowEn), .tick(tick)
  );

  esCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .parityMode(parityMode),
    .tc(tc), .match(match), .strobe(strobe)
  );

  esDatapath #(.DATA_W(DATA_W), .MSG_LEN(MSG_LEN), .POLY(POLY)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .msgBit(msgBit), .sw(sw),
    .parityMode(parityMode), .msgAddr(msgAddr), .tc(tc), .match(match),
    .result(result)
  );

  assign done = strobe.halt;
endmodule

// File: tb/errLocateSeq_bench.sv
module errLocateSeq_bench;
  logic clk = 1'b0;
  logic rstN, slowEn, parityMode, msgBit;
  logic [7:0] sw, msgAddr, result;
  logic done;
  logic [255:0] msg;
  int nChecks = 0, nFail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign msgBit = msg[msgAddr];

  errLocateSeq u_errLocateSeq (
    .clk(clk), .rstN(rstN), .slowEn(slowEn), .parityMode(parityMode),
    .sw(sw), .msgBit(msgBit), .msgAddr(msgAddr), .done(done), .result(result)
  );

  // behavioural reference, updated on each clock
  int mCnt, mPre;
  logic [7:0] mLfsr;
  bit mDone;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 0; mPre = 0; mLfsr = 8'h00; mDone = 0;
    end else begin
      bit tk;
      bit b;
      if (slowEn) begin tk = (mPre == 65535); mPre = (mPre + 1) % 65536; end
      else tk = 1;
      if (!mDone) begin
        if (!parityMode && mLfsr == sw) mDone = 1;
        else if (tk) begin
          b = (mCnt >= 248) ? sw[255 - mCnt] : msg[mCnt];
          mLfsr = ({mLfsr[6:0], b}) ^ (mLfsr[7] ? 8'h1D : 8'h00);
          if (mCnt == 255) mDone = 1; else mCnt = mCnt + 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R5/R8 done vs model", int'(done), int'(mDone));
      chk("R2 msgAddr vs model", int'(msgAddr), mCnt);
      chk("R3 result vs model", int'(result), parityMode ? int'(mLfsr) : mCnt);
    end
  end

  function automatic logic [7:0] refParity(input logic [255:0] m, input logic [7:0] s);
    logic [7:0] st = 8'h00;
    for (int i = 0; i < 256; i++) begin
      logic b = (i >= 248) ? s[255 - i] : m[i];
      st = ({st[6:0], b}) ^ (st[7] ? 8'h1D : 8'h00);
    end
    return st;
  endfunction

  function automatic int refStop(input logic [255:0] m, input logic [7:0] s);
    logic [7:0] st = 8'h00;
    for (int i = 0; i < 256; i++) begin
      logic b;
      if (st == s) return i;
      b = (i >= 248) ? s[255 - i] : m[i];
      st = ({st[6:0], b}) ^ (st[7] ? 8'h1D : 8'h00);
    end
    return 255;
  endfunction

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  task automatic runDone(output int clocks);
    clocks = 0;
    while (!done && clocks < 70000) begin @(negedge clk); clocks++; end
  endtask

  initial begin
    int clocks, expStop;
    logic [7:0] parity, synd;
    logic [31:0] lcg;
    rstN = 1'b0; slowEn = 1'b0; parityMode = 1'b1; sw = 8'h00; msg = '0;
    lcg = 32'h1234_5678;
    for (int i = 0; i < 256; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      msg[i] = lcg[29];
    end
    doReset();
    chk("R1 done after reset", int'(done), 0);
    chk("R1 msgAddr after reset", int'(msgAddr), 0);
    chk("R1 result after reset", int'(result), 0);

    runDone(clocks);
    chk("R5 parity-mode step count", clocks, 256);
    chk("R3 parity value", int'(result), int'(refParity(msg, 8'h00)));
    parity = result;

    msg[255:248] = 8'hFF; sw = parity;
    doReset(); runDone(clocks);
    chk("R4 appended check bits give zero", int'(result), 0);

    msg[37] = ~msg[37];
    doReset(); runDone(clocks);
    chk("R3 syndrome of flipped bit", int'(result), int'(refParity(msg, parity)));
    synd = result;
    chk("R3 syndrome non-zero", int'(synd != 0), 1);

    parityMode = 1'b0; sw = synd;
    expStop = refStop(msg, synd);
    doReset(); runDone(clocks);
    chk("R6 locate stop count", int'(result), expStop);
    chk("R6 locate stop clocks", clocks, expStop + 1);

    sw = 8'h00;
    doReset(); @(negedge clk);
    chk("R6 immediate match done", int'(done), 1);
    chk("R6 immediate match result", int'(result), 0);

    msg = '0; sw = 8'h03;
    doReset(); runDone(clocks);
    chk("R7 no-match result", int'(result), 255);
    chk("R7 no-match clocks", clocks, 256);

    parityMode = 1'b1; sw = 8'h00;
    doReset(); @(negedge clk);
    chk("R10 match ignored in parity mode", int'(done), 0);
    runDone(clocks);
    chk("R10 full run length", clocks, 255);
    chk("R10 final state", int'(result), 0);

    msg = '1; sw = 8'hFF;
    repeat (20) @(negedge clk);
    chk("R8 done held", int'(done), 1);
    chk("R8 state frozen", int'(result), 0);
    chk("R8 count frozen", int'(msgAddr), 255);
    parityMode = 1'b0; @(negedge clk);
    chk("R8 count view", int'(result), 255);
    parityMode = 1'b1;

    slowEn = 1'b1; sw = 8'h00;
    doReset();
    repeat (65535) @(negedge clk);
    chk("R9 no step before 65536 clocks", int'(msgAddr), 0);
    @(negedge clk);
    chk("R9 first slow step", int'(msgAddr), 1);
    chk("R9 still running", int'(done), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule